// File: doc/BRIEF.md
# Delayed-Branch Next-PC Sequencer

This block produces the fetch program counter for a simple in-order, five-stage pipeline whose instruction set has architectural branch delay slots. Each cycle it is given the decoded branch kind of the instruction at the current PC, two register operands and a branch target. Only cheap conditions are evaluated: operand equality through an XOR reduction, and a sign test of one operand. A two-register magnitude compare, which would need a carry chain, is not a branch condition. A taken branch does not redirect at once. The next `SLOTS` sequential instructions (1, 2 or 3, set by a parameter) always execute, and fetch moves to the target only after the last of them.

The block also keeps the restart state for the exception logic around it. When an instruction faults, it records the faulting PC and the address that should follow it. A fault that lands in a delay slot also sets a flag. In that case the second address is the pending branch target when the fault hits the last slot. A branch placed inside a delay slot has no defined meaning. The block reports it on an error output and otherwise ignores it.

Top module: `dslot_pc_seq`

## Requirements
- R1: While synchronous reset is high, the PC equals the `RESET_VEC` parameter, no branch is pending, both restart addresses are zero and the slot flag is low.
- R2: An instruction of kind 0, or of the unused codes 6 or 7, that is outside a delay slot moves the PC to PC+4 on the next cycle. A branch that is not taken does the same.
- R3: Kind 1 is taken exactly when `op_a_i == op_b_i`. Kind 2 is taken exactly when the two operands differ.
- R4: Kind 3 is taken exactly when bit XLEN-1 of `op_a_i` is 1. Kind 4 is taken exactly when that bit is 0. Kind 5 is always taken. `op_b_i` has no effect on kinds 3, 4 and 5.
- R5: When a branch at address P is taken outside a delay slot, the next SLOTS PCs are P+4, P+8, and so on up to P+4*SLOTS. The PC after those is the target that was presented with the branch.
- R6: A branch kind (codes 1 to 5) presented while the current instruction is in a delay slot raises `slot_branch_err_o` in that same cycle. It changes neither the PC sequence nor the pending target.
- R7: A fault on an instruction at P outside a delay slot sets `epc_o` = P and `epc_next_o` = P+4, and clears `epc_in_slot_o`, all from the next cycle on.
- R8: A fault on an instruction at P inside a delay slot sets `epc_o` = P and `epc_in_slot_o` = 1. It sets `epc_next_o` to the pending target if P is the last slot, and to P+4 otherwise.
- R9: `fault_i` has no effect on the PC sequence. Between faults, the restart outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_kind_i | input | 3 | Branch kind of the instruction at `pc_o` (0 none, 1 eq, 2 ne, 3 ltz, 4 gez, 5 jump) |
| op_a_i | input | XLEN | First register operand |
| op_b_i | input | XLEN | Second register operand (used by kinds 1 and 2) |
| target_i | input | XLEN | Branch target address |
| fault_i | input | 1 | The instruction at `pc_o` raised an exception |
| pc_o | output | XLEN | Current fetch PC |
| epc_o | output | XLEN | Recorded restart address |
| epc_next_o | output | XLEN | Recorded address following the restart address |
| epc_in_slot_o | output | 1 | Recorded fault was in a delay slot |
| slot_branch_err_o | output | 1 | Branch kind seen inside a delay slot |

## Verification
The most interesting coincidence is a fault on the last delay slot, in the same cycle as the redirect to the target. Here the recorded next address must be the target and not PC+4, and the PC must still redirect. A second coincidence is a branch placed inside a slot while a fault also hits that slot. The bench provokes both by sweeping every branch kind and operand pattern, moving a single fault across the branch and each instruction after it, and moving a stray jump across the same positions. The same stimulus drives three instances with one, two and three slots. Each instance is judged against its own arithmetic model of PC, pending count, target and restart state.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [2:0] {
        BK_NONE = 3'd0,
        BK_EQ   = 3'd1,
        BK_NE   = 3'd2,
        BK_LTZ  = 3'd3,
        BK_GEZ  = 3'd4,
        BK_JMP  = 3'd5
    } br_kind_e;

    localparam int unsigned PC_STEP = 4;

    function automatic logic is_branch(input logic [2:0] kind);
        return (kind >= 3'd1) && (kind <= 3'd5);
    endfunction

endpackage

// File: rtl/dsq_cond.sv
module dsq_cond #(
    parameter int XLEN = 32
) (
    input  logic [2:0]      kind,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            taken
);
    import dsq_pkg::*;

    logic any_diff;
    logic neg_a;

    assign any_diff = |(op_a ^ op_b);
    assign neg_a    = op_a[XLEN-1];

    always_comb begin
        case (br_kind_e'(kind))
            BK_EQ:   taken = ~any_diff;
            BK_NE:   taken = any_diff;
            BK_LTZ:  taken = neg_a;
            BK_GEZ:  taken = ~neg_a;
            BK_JMP:  taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/dsq_slot_track.sv
module dsq_slot_track #(
    parameter int XLEN  = 32,
    parameter int SLOTS = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            is_br,
    input  logic            taken,
    input  logic [XLEN-1:0] target,
    output logic            in_slot,
    output logic            last_slot,
    output logic [XLEN-1:0] held_target,
    output logic            nest_err
);
    logic start;
    logic [XLEN-1:0] tgt_q;

    assign start       = taken & ~in_slot;
    assign nest_err    = is_br & in_slot;
    assign held_target = tgt_q;

    always_ff @(posedge clk) begin
        if (rst)        tgt_q <= '0;
        else if (start) tgt_q <= target;
    end

    generate
        if (SLOTS == 1) begin : g_single
            logic busy_q;
            always_ff @(posedge clk) begin
                if (rst) busy_q <= 1'b0;
                else     busy_q <= start;
            end
            assign in_slot   = busy_q;
            assign last_slot = busy_q;
        end else begin : g_multi
            localparam int CW = $clog2(SLOTS + 1);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)                cnt_q <= '0;
                else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
                else if (start)         cnt_q <= CW'(SLOTS);
            end
            assign in_slot   = (cnt_q != '0);
            assign last_slot = (cnt_q == CW'(1));

            // R5: counter stays within the configured slot count
            a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst)
                cnt_q <= CW'(SLOTS));
            // R5: a fresh branch loads the full slot count
            a_r5_cnt_load: assert property (@(posedge clk) disable iff (rst)
                start |=> cnt_q == CW'(SLOTS));
        end
    endgenerate

    // R6: error only inside a slot
    a_r6_err_in_slot: assert property (@(posedge clk) disable iff (rst)
        nest_err |-> in_slot);
    // R6: a branch inside a slot leaves the pending target alone
    a_r6_tgt_kept: assert property (@(posedge clk) disable iff (rst)
        in_slot |=> tgt_q == $past(tgt_q));
    // R5: the window closes after the last slot
    a_r5_slot_closes: assert property (@(posedge clk) disable iff (rst)
        last_slot |=> !in_slot);
    // R5: a taken branch opens the window
    a_r5_slot_opens: assert property (@(posedge clk) disable iff (rst)
        start |=> in_slot);

endmodule

// File: rtl/dsq_restart.sv
module dsq_restart #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fault,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] next_pc,
    input  logic            in_slot,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] epc_next,
    output logic            epc_slot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc      <= '0;
            epc_next <= '0;
            epc_slot <= 1'b0;
        end else if (fault) begin
            epc      <= pc;
            epc_next <= next_pc;
            epc_slot <= in_slot;
        end
    end

    // R7, R8: the faulting PC is captured
    a_r7_epc_capture: assert property (@(posedge clk) disable iff (rst)
        fault |=> epc == $past(pc));
    // R7: a fault outside a slot clears the slot flag
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (fault && !in_slot) |=> !epc_slot);
    // R9: restart state holds between faults
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !fault |=> $stable(epc) && $stable(epc_next) && $stable(epc_slot));

endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq #(
    parameter int              XLEN      = 32,
    parameter int              SLOTS     = 1,
    parameter logic [XLEN-1:0] RESET_VEC = XLEN'(32'h0000_0100)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      br_kind_i,
    input  logic [XLEN-1:0] op_a_i,
    input  logic [XLEN-1:0] op_b_i,
    input  logic [XLEN-1:0] target_i,
    input  logic            fault_i,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] epc_next_o,
    output logic            epc_in_slot_o,
    output logic            slot_branch_err_o
);
    import dsq_pkg::*;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] next_pc;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] held_tgt;
    logic            taken;
    logic            in_slot;
    logic            last_slot;

    dsq_cond #(.XLEN(XLEN)) u_cond (
        .kind  (br_kind_i),
        .op_a  (op_a_i),
        .op_b  (op_b_i),
        .taken (taken)
    );

    dsq_slot_track #(.XLEN(XLEN), .SLOTS(SLOTS)) u_track (
        .clk         (clk),
        .rst         (rst),
        .is_br       (is_branch(br_kind_i)),
        .taken       (taken),
        .target      (target_i),
        .in_slot     (in_slot),
        .last_slot   (last_slot),
        .held_target (held_tgt),
        .nest_err    (slot_branch_err_o)
    );

    assign seq_pc  = pc_q + XLEN'(PC_STEP);
    assign next_pc = last_slot ? held_tgt : seq_pc;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_VEC;
        else     pc_q <= next_pc;
    end

    assign pc_o = pc_q;

    dsq_restart #(.XLEN(XLEN)) u_restart (
        .clk      (clk),
        .rst      (rst),
        .fault    (fault_i),
        .pc       (pc_q),
        .next_pc  (next_pc),
        .in_slot  (in_slot),
        .epc      (epc_o),
        .epc_next (epc_next_o),
        .epc_slot (epc_in_slot_o)
    );

    // R2: outside a slot, an untaken instruction steps by one word
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!in_slot && !taken) |=> pc_q == $past(pc_q) + XLEN'(PC_STEP));
    // R5: a taken branch does not redirect at once
    a_r5_no_early: assert property (@(posedge clk) disable iff (rst)
        (!in_slot && taken) |=> pc_q == $past(pc_q) + XLEN'(PC_STEP));
    // R5: the last slot hands over to the held target
    a_r5_redirect: assert property (@(posedge clk) disable iff (rst)
        last_slot |=> pc_q == $past(held_tgt));
    // R8: a fault in the last slot records the target as the follower
    a_r8_last_slot: assert property (@(posedge clk) disable iff (rst)
        (fault_i && last_slot) |=> epc_next_o == $past(held_tgt) && epc_in_slot_o);

endmodule

// File: tb/dslot_pc_seq_test.sv
module dslot_pc_seq_test;
    localparam logic [31:0] RV = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  kind_i = '0;
    logic [31:0] a_i = '0, b_i = '0, t_i = '0;
    logic        flt_i = 1'b0;

    logic [31:0] pc_w[1:3], epc_w[1:3], epcn_w[1:3];
    logic        slot_w[1:3], err_w[1:3];

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_pc[1:3], m_tgt[1:3], m_ret[1:3], m_retn[1:3];
    int          m_cnt[1:3];
    bit          m_flag[1:3];

    always #10 clk = ~clk;

    dslot_pc_seq #(.XLEN(32), .SLOTS(1), .RESET_VEC(RV)) uut (
        .clk(clk), .rst(rst), .br_kind_i(kind_i), .op_a_i(a_i), .op_b_i(b_i),
        .target_i(t_i), .fault_i(flt_i), .pc_o(pc_w[1]), .epc_o(epc_w[1]),
        .epc_next_o(epcn_w[1]), .epc_in_slot_o(slot_w[1]), .slot_branch_err_o(err_w[1]));
    dslot_pc_seq #(.XLEN(32), .SLOTS(2), .RESET_VEC(RV)) uut_s2 (
        .clk(clk), .rst(rst), .br_kind_i(kind_i), .op_a_i(a_i), .op_b_i(b_i),
        .target_i(t_i), .fault_i(flt_i), .pc_o(pc_w[2]), .epc_o(epc_w[2]),
        .epc_next_o(epcn_w[2]), .epc_in_slot_o(slot_w[2]), .slot_branch_err_o(err_w[2]));
    dslot_pc_seq #(.XLEN(32), .SLOTS(3), .RESET_VEC(RV)) uut_s3 (
        .clk(clk), .rst(rst), .br_kind_i(kind_i), .op_a_i(a_i), .op_b_i(b_i),
        .target_i(t_i), .fault_i(flt_i), .pc_o(pc_w[3]), .epc_o(epc_w[3]),
        .epc_next_o(epcn_w[3]), .epc_in_slot_o(slot_w[3]), .slot_branch_err_o(err_w[3]));

    task automatic chk(input bit ok, input string tag, input int k, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s slots=%0d %s actual=%h expected=%h", tag, k, what, act, exp);
        end
    endtask

    function automatic bit ref_taken(input int kind, input logic [31:0] a, input logic [31:0] b);
        case (kind)
            1: return a == b;
            2: return a != b;
            3: return a[31];
            4: return !a[31];
            5: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic step(input int kind, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] tg, input bit flt);
        string tag[1:3];
        kind_i = 3'(kind); a_i = a; b_i = b; t_i = tg; flt_i = flt;
        #1;
        for (int k = 1; k <= 3; k++) begin
            bit exp_err = (m_cnt[k] != 0) && (kind >= 1) && (kind <= 5);
            chk(err_w[k] == exp_err, "R6", k, "slot_branch_err", 32'(err_w[k]), 32'(exp_err));
        end
        for (int k = 1; k <= 3; k++) begin
            logic [31:0] nxt;
            bit was_slot = (m_cnt[k] != 0);
            if (was_slot) begin
                nxt = (m_cnt[k] == 1) ? m_tgt[k] : m_pc[k] + 32'd4;
                tag[k] = (m_cnt[k] == 1) ? "R5" : ((kind >= 1 && kind <= 5) ? "R6" : "R5");
                m_cnt[k]--;
            end else begin
                nxt = m_pc[k] + 32'd4;
                if (kind == 1 || kind == 2)      tag[k] = "R3";
                else if (kind >= 3 && kind <= 5) tag[k] = "R4";
                else                              tag[k] = "R2";
                if (ref_taken(kind, a, b)) begin
                    m_cnt[k] = k;
                    m_tgt[k] = tg;
                end
            end
            if (flt) begin
                m_ret[k] = m_pc[k]; m_retn[k] = nxt; m_flag[k] = was_slot;
                tag[k] = "R9";
            end
            m_pc[k] = nxt;
        end
        @(posedge clk); @(negedge clk);
        flt_i = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            string rt = m_flag[k] ? "R8" : "R7";
            chk(pc_w[k] == m_pc[k], tag[k], k, "pc", pc_w[k], m_pc[k]);
            chk(epc_w[k] == m_ret[k], rt, k, "epc", epc_w[k], m_ret[k]);
            chk(epcn_w[k] == m_retn[k], rt, k, "epc_next", epcn_w[k], m_retn[k]);
            chk(slot_w[k] == m_flag[k], rt, k, "epc_in_slot", 32'(slot_w[k]), 32'(m_flag[k]));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa[4], pb[4];
        pa[0] = 32'h1234_5678; pb[0] = 32'h1234_5678;
        pa[1] = 32'h1234_5678; pb[1] = 32'h1234_5679;
        pa[2] = 32'h8000_0000; pb[2] = 32'h8000_0000;
        pa[3] = 32'h0000_0000; pb[3] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        for (int k = 1; k <= 3; k++) begin
            chk(pc_w[k] == RV, "R1", k, "reset pc", pc_w[k], RV);
            chk(epc_w[k] == 0 && epcn_w[k] == 0, "R1", k, "reset epc", epc_w[k] | epcn_w[k], 0);
            chk(slot_w[k] == 0 && err_w[k] == 0, "R1", k, "reset flags", 32'({slot_w[k], err_w[k]}), 0);
            m_pc[k] = RV; m_cnt[k] = 0; m_tgt[k] = '0;
            m_ret[k] = '0; m_retn[k] = '0; m_flag[k] = 0;
        end
        rst = 1'b0;
        for (int kd = 0; kd < 8; kd++)
            for (int p = 0; p < 4; p++)
                for (int fp = 0; fp < 6; fp++)
                    for (int ns = 1; ns <= 4; ns++) begin
                        logic [31:0] tg = 32'h0001_0000 + 32'((kd * 96 + p * 24 + fp * 4 + ns) * 64);
                        step(kd, pa[p], pb[p], tg, fp == 0);
                        for (int j = 1; j <= 4; j++)
                            step((j == ns) ? 5 : ((j == 2) ? 7 : 0), pa[(p + j) % 4], pb[p],
                                 tg + 32'h0000_8000, fp == j);
                    end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule